// File: doc/BRIEF.md
# NAND Hamming ECC Accumulator

This block sits beside the data path of a NAND flash controller and builds a single-error-correcting Hamming code over the bytes moving between the controller and the flash. Each 256-byte granule gets a 3-byte code. The block holds up to `GRANULES` granule codes, so one 512-byte sector yields six code bytes when `GRANULES` is 2.

Software drives a 2-bit mode field. The four values select off, accumulate, read-out and clear. The usual sequence before a transfer is clear, then off, then accumulate. After the transfer it is off, then read-out, then off. In read-out mode the code bytes appear one after another on `code_out`, which feeds the shared data register. Each `rd_strobe` advances to the next byte. Comparing a stored code with a fresh one and fixing the bad bit is left to software.

Line parity covers address bit k of the byte within its granule and is a pair: LP(2k) is the XOR of the byte parities of all bytes whose address bit k is 0, and LP(2k+1) is the same over bytes whose bit k is 1. Column parity is computed over bit positions of the data: CP0 covers bits 0,2,4,6; CP1 covers 1,3,5,7; CP2 covers 0,1,4,5; CP3 covers 2,3,6,7; CP4 covers 3:0; CP5 covers 7:4. Every stored parity bit is inverted.

Top module: `nand_ecc_acc`

## Requirements
- R1: Mode 2'b11 (clear) zeroes all parity state, the byte address and the granule index within one clock, so a following read-out returns 8'hFF for every code byte.
- R2: In mode 2'b00 (off), data-path bytes change no parity or counter state; a later read-out shows only bytes taken in accumulate mode.
- R3: In mode 2'b01 (accumulate), each cycle with `byte_valid` high folds `byte_data` into the current granule. Code byte 0 bit i is the inverse of LP(i), and code byte 1 bit i is the inverse of LP(8+i). A single 8'h01 at address 0 gives code bytes 0/1/2 of 8'hAA/8'hAA/8'hAB.
- R4: In mode 2'b10 (read-out), successive reads return code byte 1, then byte 0, then byte 2 of granule 0, then the same order for each following granule.
- R5: Code byte 2 carries the inverted CP5..CP0 in bits 7:2, and its bits 1:0 always read as 1.
- R6: After the 256th byte of a granule, accumulation moves to the next granule's parity set, and each granule's code depends only on its own bytes.
- R7: Once `GRANULES`×256 bytes have been taken, further bytes are ignored until the next clear.
- R8: After the last code byte has been read, the next read starts again at byte 1 of granule 0. Leaving read-out mode also resets the read position to that point.
- R9: Outside read-out mode `code_out` is 8'h00.
- R10: An erased sector (all bytes 8'hFF) gives an all-ones code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 off, 01 accumulate, 10 read-out, 11 clear |
| byte_valid | input | 1 | A byte moves on the flash data path this cycle |
| byte_data | input | 8 | Byte on the flash data path |
| rd_strobe | input | 1 | Data-register read in read-out mode; advances the code byte |
| code_out | output | 8 | Current code byte in read-out mode, else zero |

## Verification
The code is tried with a lone 8'h01 byte, whose code is known in closed form, and with an erased sector of all 8'hFF. It is also tried with an address-dependent pattern of two granules, checked against an independent bench model. Together these separate errors in line-parity pairing, column grouping and inversion. Two further cases use the same pattern. In one, junk bytes are injected in off mode, which shows whether the off state really holds. In the other, the stream runs past the sector end, which shows whether the granule index saturates. Reading past the last code byte shows the read order and the wrap point.

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc #(
  parameter int GRANULES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  input  logic       rd_strobe,
  output logic [7:0] code_out
);
  localparam int GW = $clog2(GRANULES + 1);
  localparam logic [1:0] M_OFF = 2'b00, M_ACC = 2'b01, M_RD = 2'b10, M_CLR = 2'b11;

  logic [15:0]   lp  [GRANULES];
  logic [7:0]    col [GRANULES];
  logic [7:0]    addr;
  logic [GW-1:0] gidx;
  logic [1:0]    rbyte;
  logic [GW-1:0] rgran;
  logic [15:0]   lp_upd;
  logic [15:0]   sel_lp;
  logic [7:0]    sel_col;
  logic [5:0]    cp;

  wire clr = !rst_n || mode == M_CLR;
  wire acc = mode == M_ACC && byte_valid && gidx < GW'(GRANULES);
  wire par = ^byte_data;

  always_comb
    for (int k = 0; k < 8; k++) begin
      lp_upd[2*k]   = par & ~addr[k];
      lp_upd[2*k+1] = par &  addr[k];
    end

  always_ff @(posedge clk)
    if (clr) begin
      addr <= '0;
      gidx <= '0;
    end else if (acc) begin
      addr <= addr + 8'd1;
      if (addr == 8'hFF) gidx <= gidx + GW'(1);
    end

  for (genvar g = 0; g < GRANULES; g++) begin : g_gran
    always_ff @(posedge clk)
      if (clr) begin
        lp[g]  <= '0;
        col[g] <= '0;
      end else if (acc && gidx == GW'(g)) begin
        lp[g]  <= lp[g] ^ lp_upd;
        col[g] <= col[g] ^ byte_data;
      end
  end

  always_ff @(posedge clk)
    if (!rst_n || mode != M_RD) begin
      rbyte <= '0;
      rgran <= '0;
    end else if (rd_strobe) begin
      if (rbyte == 2'd2) begin
        rbyte <= '0;
        rgran <= (rgran == GW'(GRANULES - 1)) ? '0 : rgran + GW'(1);
      end else
        rbyte <= rbyte + 2'd1;
    end

  always_comb begin
    sel_lp  = '0;
    sel_col = '0;
    for (int g = 0; g < GRANULES; g++)
      if (rgran == GW'(g)) begin
        sel_lp  = lp[g];
        sel_col = col[g];
      end
  end

  assign cp = {^sel_col[7:4], ^sel_col[3:0],
               ^{sel_col[7:6], sel_col[3:2]}, ^{sel_col[5:4], sel_col[1:0]},
               ^{sel_col[7], sel_col[5], sel_col[3], sel_col[1]},
               ^{sel_col[6], sel_col[4], sel_col[2], sel_col[0]}};

  always_comb
    if (mode != M_RD) code_out = 8'h00;
    else case (rbyte)
      2'd0:    code_out = ~sel_lp[15:8];
      2'd1:    code_out = ~sel_lp[7:0];
      default: code_out = {~cp, 2'b11};
    endcase

  a_r1_clear_counters: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_CLR |=> addr == 8'd0 && gidx == '0);
  a_r2_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_OFF |=> $stable(addr) && $stable(gidx));
  a_r5_tail_ones: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_RD && rbyte == 2'd2 |-> code_out[1:0] == 2'b11);
  a_r6_granule_step: assert property (@(posedge clk) disable iff (!rst_n)
    acc && addr == 8'hFF |=> gidx == $past(gidx) + GW'(1));
  a_r7_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    gidx <= GW'(GRANULES));
  a_r8_read_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_RD && rd_strobe && rbyte == 2'd2 && rgran == GW'(GRANULES - 1)
    |=> rbyte == 2'd0 && rgran == '0);
endmodule

// File: tb/tb_nand_ecc_acc.sv
`timescale 1ns/1ps
module tb_nand_ecc_acc;
  logic clk = 0, rst_n = 0, byte_valid = 0, rd_strobe = 0;
  logic [1:0] mode = 2'b00;
  logic [7:0] byte_data = 0;
  logic [7:0] code_out;
  int checks = 0, errors = 0;
  logic [7:0] sbuf [512];
  logic [7:0] exp_code [6];

  nand_ecc_acc #(.GRANULES(2)) dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic model(input int nbytes);
    for (int g = 0; g < 2; g++) begin
      logic [15:0] l = 0;
      logic [5:0] c = 0;
      for (int a = 0; a < 256; a++) begin
        int idx = g * 256 + a;
        logic [7:0] d;
        d = (idx < nbytes) ? sbuf[idx] : 8'h00;
        for (int k = 0; k < 8; k++)
          if ((a >> k) & 1) l[2*k+1] ^= ^d; else l[2*k] ^= ^d;
        for (int b = 0; b < 8; b++) begin
          if (b % 2 == 0) c[0] ^= d[b]; else c[1] ^= d[b];
          if ((b & 2) == 0) c[2] ^= d[b]; else c[3] ^= d[b];
          if (b < 4) c[4] ^= d[b]; else c[5] ^= d[b];
        end
      end
      exp_code[3*g]   = ~l[15:8];
      exp_code[3*g+1] = ~l[7:0];
      exp_code[3*g+2] = {~c, 2'b11};
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode = m; @(negedge clk);
  endtask

  task automatic feed(input int n, input int from);
    for (int i = 0; i < n; i++) begin
      byte_valid = 1; byte_data = sbuf[(from + i) % 512]; @(negedge clk);
    end
    byte_valid = 0;
  endtask

  task automatic read_all(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      #1 chk(req, code_out, exp_code[i % 6]);
      rd_strobe = 1; @(negedge clk); rd_strobe = 0;
    end
  endtask

  task automatic start();
    set_mode(2'b11); set_mode(2'b00); mode = 2'b01;
  endtask

  task automatic t_reset();
    #1 chk("R9 idle after reset", code_out, 8'h00);
    for (int i = 0; i < 6; i++) exp_code[i] = 8'hFF;
    set_mode(2'b10); read_all("R1 reset state", 6); set_mode(2'b00);
  endtask

  task automatic t_single();
    start(); sbuf[0] = 8'h01; feed(1, 0); set_mode(2'b00);
    set_mode(2'b10);
    #1 chk("R3 byte1", code_out, 8'hAA);
    rd_strobe = 1; @(negedge clk); rd_strobe = 0;
    #1 chk("R3 byte0", code_out, 8'hAA);
    rd_strobe = 1; @(negedge clk); rd_strobe = 0;
    #1 chk("R5 byte2", code_out, 8'hAB);
    set_mode(2'b00);
  endtask

  task automatic t_erased();
    for (int i = 0; i < 512; i++) sbuf[i] = 8'hFF;
    start(); feed(512, 0); set_mode(2'b00);
    for (int i = 0; i < 6; i++) exp_code[i] = 8'hFF;
    set_mode(2'b10); read_all("R10 erased", 6); set_mode(2'b00);
  endtask

  task automatic fill();
    for (int i = 0; i < 512; i++) sbuf[i] = 8'((i * 37 + (i >> 3) * 11 + 5) ^ (i >> 8));
  endtask

  task automatic t_pattern();
    fill(); start(); feed(512, 0);
    #1 chk("R9 idle in accumulate", code_out, 8'h00);
    set_mode(2'b00); model(512);
    set_mode(2'b10); read_all("R4 R6 pattern order", 6);
    read_all("R8 wrap", 2);
    set_mode(2'b00); set_mode(2'b10); read_all("R8 restart", 1); set_mode(2'b00);
  endtask

  task automatic t_off();
    fill(); start(); feed(200, 0); set_mode(2'b00);
    feed(40, 300); mode = 2'b01; feed(100, 200); set_mode(2'b00);
    model(300); set_mode(2'b10); read_all("R2 off ignored", 6); set_mode(2'b00);
  endtask

  task automatic t_overflow();
    fill(); start(); feed(512, 0); feed(30, 7); set_mode(2'b00);
    model(512); set_mode(2'b10); read_all("R7 overflow ignored", 6); set_mode(2'b00);
  endtask

  task automatic t_clear_after();
    fill(); start(); feed(100, 0); set_mode(2'b11); set_mode(2'b00);
    for (int i = 0; i < 6; i++) exp_code[i] = 8'hFF;
    set_mode(2'b10); read_all("R1 clear", 6); set_mode(2'b00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
        t_reset(); t_single(); t_erased(); t_pattern();
        t_off(); t_overflow(); t_clear_after();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule